// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

A watchdog counter behind a small 32-bit register port. Writes complete in the cycle they are presented, and reads return data combinationally from the decoded address. While it is enabled, the counter advances once per clock. It must be serviced with an ordered pair of 16-bit key words before it reaches the programmed limit. If it is not serviced, the block drives a one-cycle reset request. If a service pair arrives too early while a nonzero early-service threshold is programmed, the block also drives the request.

The configuration registers (control, limit, threshold) are writable freely until the control register is written for the first time. After that, a write is taken only if the update-permission bit from the last control write is set and a separate two-word unlock pair has opened a write window within the last 128 cycles. If the control register is written with the update bit clear, the configuration is frozen until reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control reads 0x080 (bit 7 enable = 1, bit 5 update permit = 0, bit 11 configured = 0), the limit reads 0x400, the threshold reads 0, and rst_req is low.
- R2: Address bits [3:2] select the register: 0 control, 1 counter on read and key word (bits 15:0) on write, 2 limit (bits 15:0), 3 early-service threshold (bits 15:0).
- R3: A service pair is 0xA602 followed by 0xB480 written to offset 0x04, with the second word at most 16 cycles after the first. It sets the counter to 0, and the counter reads 0 right after the second word's edge.
- R4: A partial pair is dropped by a wrong second word, by a reversed order, by a 0x1234-style stray word between the two words, or by a second word arriving 17 or more cycles after the first. A dropped pair has no effect on the counter.
- R5: While enabled, the counter increments every clock. rst_req is high for exactly the one cycle in which the counter equals the limit, and the counter then restarts at 0. While disabled, the counter holds its value.
- R6: Before the first control write, the limit, threshold and control registers are written directly. A control write sets the configured bit.
- R7: Once configured, a write to control, limit or threshold is taken only when the update bit is set and an unlock pair (0xC520 then 0xD928 at offset 0x04, same 16-cycle rule) completed at most 128 cycles earlier. All other such writes are ignored.
- R8: Writing 0x120 to control clears enable and sets update permit. Control then reads 0x820.
- R9: If the threshold is nonzero, the block is enabled, and a service pair completes while the counter is below the threshold, rst_req is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume that each bus write lasts exactly one cycle and carries a stable address and data word. The bench drives every write at a falling edge and removes the strobe at the next falling edge, so a write never spans two rising edges. The properties also assume the limit is nonzero and larger than the counter whenever the counter is enabled. The stimulus keeps the limit at 20 or more and reprograms it only after servicing or while counting is off.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CW = 16,
  parameter int KEY_GAP = 16,
  parameter int CFG_OPEN = 128,
  parameter logic [CW-1:0] TOUT_INIT = 'h400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);
  localparam int AW = $clog2(KEY_GAP + 1);
  localparam int OW = $clog2(CFG_OPEN + 1);

  typedef enum logic [1:0] {K_IDLE, K_UNLK, K_SERV} kst_t;

  kst_t          kst;
  logic [AW-1:0] kage;
  logic [OW-1:0] ocnt;
  logic [CW-1:0] cnt, tout, win;
  logic          en, upd, cfgd;

  wire [15:0] wk      = bus_wdata[15:0];
  wire        key_wr  = bus_we && bus_addr[3:2] == 2'd1;
  wire        in_time = kage < AW'(KEY_GAP);
  wire        unlock_ok = key_wr && wk == 16'hD928 && kst == K_UNLK && in_time;
  wire        ref_ok    = key_wr && wk == 16'hB480 && kst == K_SERV && in_time;
  wire        cfg_ok  = !cfgd || (upd && ocnt != '0);
  wire        ctrl_wr = bus_we && bus_addr[3:2] == 2'd0 && cfg_ok;
  wire        tout_wr = bus_we && bus_addr[3:2] == 2'd2 && cfg_ok;
  wire        win_wr  = bus_we && bus_addr[3:2] == 2'd3 && cfg_ok;
  wire        cnt_hit = cnt == tout;
  wire [CW-1:0] cnt_inc = cnt + 1'b1;
  wire        viol    = ref_ok && en && win != '0 && cnt < win;

  logic unused_bits;
  assign unused_bits = &{1'b0, bus_wdata[31:16], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kst  <= K_IDLE;
      kage <= '0;
    end else if (key_wr) begin
      kage <= '0;
      if (wk == 16'hC520)      kst <= K_UNLK;
      else if (wk == 16'hA602) kst <= K_SERV;
      else                     kst <= K_IDLE;
    end else if (kst != K_IDLE) begin
      if (kage == AW'(KEY_GAP - 1)) kst <= K_IDLE;
      else                          kage <= kage + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ocnt <= '0;
    else if (unlock_ok)      ocnt <= OW'(CFG_OPEN);
    else if (ocnt != '0)     ocnt <= ocnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b1;
      upd  <= 1'b0;
      cfgd <= 1'b0;
      tout <= TOUT_INIT;
      win  <= '0;
    end else begin
      if (ctrl_wr) begin
        en   <= bus_wdata[7];
        upd  <= bus_wdata[5];
        cfgd <= 1'b1;
      end
      if (tout_wr) tout <= bus_wdata[CW-1:0];
      if (win_wr)  win  <= bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      if (ref_ok)  cnt <= '0;
      else if (en) cnt <= cnt_hit ? '0 : cnt_inc;
      rst_req <= viol || (en && !ref_ok && !cnt_hit && cnt_inc == tout);
    end
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {20'b0, cfgd, 3'b0, en, 1'b0, upd, 5'b0};
      2'd1:    bus_rdata = {{(32-CW){1'b0}}, cnt};
      2'd2:    bus_rdata = {{(32-CW){1'b0}}, tout};
      default: bus_rdata = {{(32-CW){1'b0}}, win};
    endcase
  end
endmodule

module keyed_wdog_props #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          cfgd,
  input logic          upd,
  input logic          ref_ok,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tout,
  input logic [CW-1:0] win,
  input logic          rst_req
);
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ref_ok) |=> cnt == $past(cnt));

  p_cfg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfgd |=> cfgd);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgd && !upd) |=> ($stable(tout) && $stable(win) && !upd));

  p_serv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok |=> cnt == '0);

  p_early_serv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && en && win != '0 && cnt < win) |=> rst_req);
endmodule

bind keyed_wdog keyed_wdog_props #(.CW(CW)) u_props (
  .clk(clk), .rst_n(rst_n), .en(en), .cfgd(cfgd), .upd(upd),
  .ref_ok(ref_ok), .cnt(cnt), .tout(tout), .win(win), .rst_req(rst_req)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_run = 0;
  int n_fail = 0;

  keyed_wdog dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  localparam int NV = 8;
  localparam logic [15:0] V_W0 [NV] = '{16'hA602, 16'hA602, 16'hA602, 16'hB480,
                                         16'hA602, 16'hC520, 16'hA602, 16'hA602};
  localparam int          V_GAP[NV] = '{1, 16, 17, 1, 1, 1, 2, 1};
  localparam logic [15:0] V_W1 [NV] = '{16'hB480, 16'hB480, 16'hB480, 16'hA602,
                                         16'hD928, 16'hB480, 16'hB480, 16'hA602};
  localparam logic        V_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic serve();
    wr(4'h4, 32'hA602);
    wr(4'h4, 32'hB480);
  endtask

  task automatic unlock();
    wr(4'h4, 32'hC520);
    wr(4'h4, 32'hD928);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'h0, v); check(v == 32'h080, "R1 control", v, 32'h080);
    rd(4'h8, v); check(v == 32'h400, "R1 limit", v, 32'h400);
    rd(4'hC, v); check(v == 32'h0, "R1 threshold", v, 32'h0);
    check(rst_req == 1'b0, "R1 rst_req", {31'b0, rst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      serve();
      repeat (3) @(negedge clk);
      wr(4'h4, {16'h0, V_W0[i]});
      repeat (V_GAP[i] - 1) @(negedge clk);
      wr(4'h4, {16'h0, V_W1[i]});
      rd(4'h4, v);
      if (V_OK[i]) check(v == 0, "R3 service pair", v, 32'h0);
      else         check(v != 0, "R4 dropped pair", v, 32'h1);
    end

    wr(4'h8, 32'd20);
    rd(4'h8, v); check(v == 32'd20, "R6 direct limit write", v, 32'd20);
    serve();
    for (int i = 1; i <= 21; i++) begin
      @(negedge clk);
      check(rst_req == (i == 20), "R5 timeout pulse", {31'b0, rst_req}, {31'b0, i == 20});
    end

    serve();
    wr(4'hC, 32'd10);
    serve();
    check(rst_req == 1'b1, "R9 early service", {31'b0, rst_req}, 32'h1);
    repeat (12) @(negedge clk);
    serve();
    check(rst_req == 1'b0, "R9 late service", {31'b0, rst_req}, 32'h0);
    rd(4'h4, v); check(v == 0, "R3 late service clears", v, 32'h0);
    wr(4'hC, 32'd0);

    wr(4'h0, 32'h120);
    rd(4'h0, v); check(v == 32'h820, "R8 control after 0x120", v, 32'h820);
    rd(4'h4, c1);
    seen = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    check(!seen, "R5 no request while off", {31'b0, seen}, 32'h0);
    rd(4'h4, c2); check(c1 == c2, "R5 counter holds while off", c2, c1);

    wr(4'h8, 32'h50);
    rd(4'h8, v); check(v == 32'd20, "R7 locked write ignored", v, 32'd20);
    unlock();
    wr(4'h8, 32'h30);
    rd(4'h8, v); check(v == 32'h30, "R7 unlocked write", v, 32'h30);

    unlock();
    repeat (127) @(negedge clk);
    wr(4'h8, 32'h31);
    rd(4'h8, v); check(v == 32'h31, "R7 write at last open cycle", v, 32'h31);
    unlock();
    repeat (128) @(negedge clk);
    wr(4'h8, 32'h32);
    rd(4'h8, v); check(v == 32'h31, "R7 write after window", v, 32'h31);

    wr(4'h4, 32'hC520);
    repeat (16) @(negedge clk);
    wr(4'h4, 32'hD928);
    wr(4'h8, 32'h33);
    rd(4'h8, v); check(v == 32'h31, "R7 late unlock word", v, 32'h31);

    unlock();
    wr(4'h0, 32'h080);
    rd(4'h0, v); check(v == 32'h880, "R7 control rewrite", v, 32'h880);
    unlock();
    wr(4'h8, 32'h40);
    rd(4'h8, v); check(v == 32'h31, "R7 frozen without update bit", v, 32'h31);

    serve();
    wr(4'h4, 32'hA602);
    wr(4'h4, 32'h1234);
    wr(4'h4, 32'hB480);
    rd(4'h4, v); check(v == 32'd3, "R4 stray word drops pair", v, 32'd3);
    @(negedge clk);
    rd(4'h4, v); check(v == 32'd4, "R5 counting resumed", v, 32'd4);
    rd(4'h4, v); check(v == 32'd4, "R2 counter read offset", v, 32'd4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule